// File: doc/BRIEF.md
# Extended Register Window for a Display Controller

This block decodes an eight-byte register window at offset 0x600 of a 4 KiB display-controller register space. The window has two 32-bit registers. The first is a read-only register that reports the window size in bytes, so that software can find out how far the window reaches. The second is a byte-order control register. It drives one output bit, `fb_big_endian`, which tells the pixel path how to interpret framebuffer words.

The byte-order state changes only when a write carries one of two exact 32-bit patterns. Any other value written to that register leaves the state as it is, so a stray or partial write cannot flip the framebuffer order. A static strap switches the whole window on or off, and the revision value reported elsewhere in the device follows that strap. Only 4-byte accesses are served, and bus data is little-endian.

Top module: `mmio_ext_window`

## Requirements
- R1: `bus_hit` is high in the same cycle exactly when `strap_en` is 1 and `bus_addr` lies in 0x600..0x607.
- R2: A 4-byte read of 0x600 returns 0x00000008, and writes to 0x600 change no state.
- R3: A 4-byte read of 0x604 returns 0xBEBEBEBE while big-endian mode is active and 0x1E1E1E1E while little-endian mode is active.
- R4: A claimed 4-byte write of 0xBEBEBEBE to 0x604 sets `fb_big_endian` to 1, and a write of 0x1E1E1E1E clears it to 0. The output changes on the clock edge that samples the write.
- R5: A write of any other value to 0x604 leaves `fb_big_endian` and the readback of 0x604 unchanged.
- R6: Reads of the window offsets 0x601–0x603 and 0x605–0x607 return zero, and writes to them change no state.
- R7: `bus_size` gives the access width in bytes, and only the value 4 is served. A claimed access of any other size changes no state and reads as zero. It also sets `bus_err` high for exactly the one cycle after the access.
- R8: While `strap_en` is 0 nothing in the window is claimed. `bus_rdata` reads zero, `bus_err` stays low, the byte-order state does not change, and `rev_id` is 1. While `strap_en` is 1, `rev_id` is 2.
- R9: After reset, `fb_big_endian` is 0, `bus_rdata` is zero and `bus_err` is low, so the first read of 0x604 returns 0x1E1E1E1E.
- R10: `bus_rdata` holds the data of an accepted read in the cycle after the strobe and is zero after every cycle without an accepted read. A read and a write of 0x604 in the same cycle return the byte order from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Static window enable strap |
| bus_addr | input | 12 | Byte address within the register space |
| bus_size | input | 3 | Access width in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_hit | output | 1 | Access falls in the enabled window |
| bus_err | output | 1 | One-cycle flag for a claimed access of the wrong size |
| fb_big_endian | output | 1 | Framebuffer is big-endian |
| rev_id | output | 8 | Revision value reported by the device |

## Verification
The bench writes values that differ from a magic pattern in a single bit, and a decoder that compares only part of the word would flip the byte order on them. It also sends wrong-size accesses that carry a magic pattern, so a design that skips the size check would change state without raising `bus_err`. It issues a read and a write of 0x604 in the same cycle, and an early-forwarding read path would return the new order instead of the old one. Lowering the strap while traffic continues shows any decoder that still claims the window or still answers reads.

// File: rtl/mmio_ext_pkg.sv
package mmio_ext_pkg;

    localparam int DATA_W    = 32;
    localparam int SIZE_W    = 3;
    localparam int WIN_BYTES = 8;
    localparam int ACC_BYTES = 4;

    localparam logic [DATA_W-1:0] ORDER_BIG    = 32'hBEBE_BEBE;
    localparam logic [DATA_W-1:0] ORDER_LITTLE = 32'h1E1E_1E1E;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_SIZE  = 2'd1,
        SEL_ORDER = 2'd2
    } sel_e;

    typedef struct packed {
        logic hit;
        logic size_ok;
        sel_e sel;
    } dec_t;

    function automatic logic [DATA_W-1:0] order_word(input logic big);
        return big ? ORDER_BIG : ORDER_LITTLE;
    endfunction

endpackage

// File: rtl/mmio_ext_decode.sv
module mmio_ext_decode
    import mmio_ext_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WIN_BASE = 'h600
) (
    input  logic              strap_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(WIN_BASE + WIN_BYTES);

    logic [ADDR_W-1:0] off;
    logic              in_win;

    always_comb begin
        off         = addr - BASE_A;
        in_win      = (addr >= BASE_A) && (addr < END_A);
        dec.hit     = strap_en && in_win;
        dec.size_ok = (size == SIZE_W'(ACC_BYTES));
        if (off == ADDR_W'(0))
            dec.sel = SEL_SIZE;
        else if (off == ADDR_W'(ACC_BYTES))
            dec.sel = SEL_ORDER;
        else
            dec.sel = SEL_NONE;
        if (!in_win)
            dec.sel = SEL_NONE;
    end
endmodule

// File: rtl/mmio_ext_order_reg.sv
module mmio_ext_order_reg
    import mmio_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    output logic              big
);
    always_ff @(posedge clk) begin
        if (rst)
            big <= 1'b0;
        else if (wr_ok) begin
            if (wdata == ORDER_BIG)
                big <= 1'b1;
            else if (wdata == ORDER_LITTLE)
                big <= 1'b0;
        end
    end

    // R4
    set_big_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wdata == ORDER_BIG) |=> big);

    // R4
    set_little_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wdata == ORDER_LITTLE) |=> !big);

    // R5
    order_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ok || (wdata != ORDER_BIG && wdata != ORDER_LITTLE)) |=> $stable(big));
endmodule

// File: rtl/mmio_ext_rdpath.sv
module mmio_ext_rdpath
    import mmio_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_en,
    input  logic              rd,
    input  logic              wr,
    input  dec_t              dec,
    input  logic              big,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    logic [DATA_W-1:0] rvalue;
    logic              rd_ok;
    logic              bad_acc;

    always_comb begin
        unique case (dec.sel)
            SEL_SIZE:  rvalue = DATA_W'(WIN_BYTES);
            SEL_ORDER: rvalue = order_word(big);
            default:   rvalue = '0;
        endcase
        rd_ok   = rd && dec.hit && dec.size_ok;
        bad_acc = (rd || wr) && dec.hit && !dec.size_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_ok ? rvalue : '0;
            err   <= bad_acc;
        end
    end

    // R10
    rdata_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata != '0) |-> $past(rd && dec.hit));

    // R8
    strap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_en |=> (rdata == '0 && !err));

    // R7
    bad_size_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !dec.size_ok) |=> (rdata == '0));
endmodule

// File: rtl/mmio_ext_window.sv
module mmio_ext_window
    import mmio_ext_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WIN_BASE = 'h600,
    parameter int REV_ON   = 2,
    parameter int REV_OFF  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_hit,
    output logic              bus_err,
    output logic              fb_big_endian,
    output logic [7:0]        rev_id
);
    dec_t dec;
    logic order_wr;

    mmio_ext_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .strap_en(strap_en),
        .addr    (bus_addr),
        .size    (bus_size),
        .dec     (dec)
    );

    assign order_wr = bus_wr && dec.hit && dec.size_ok && (dec.sel == SEL_ORDER);

    mmio_ext_order_reg u_order (
        .clk  (clk),
        .rst  (rst),
        .wr_ok(order_wr),
        .wdata(bus_wdata),
        .big  (fb_big_endian)
    );

    mmio_ext_rdpath u_rd (
        .clk     (clk),
        .rst     (rst),
        .strap_en(strap_en),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .dec     (dec),
        .big     (fb_big_endian),
        .rdata   (bus_rdata),
        .err     (bus_err)
    );

    assign bus_hit = dec.hit;
    assign rev_id  = strap_en ? 8'(REV_ON) : 8'(REV_OFF);

    // R8
    strap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_en |=> $stable(fb_big_endian));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_hit && bus_size != 3'd4));
endmodule

// File: tb/mmio_ext_window_tb.sv
module mmio_ext_window_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        strap_en;
    logic [11:0] bus_addr;
    logic [2:0]  bus_size;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        bus_hit;
    logic        bus_err;
    logic        fb_big_endian;
    logic [7:0]  rev_id;

    int checks = 0;
    int fails  = 0;
    logic model_be = 1'b0;

    localparam logic [31:0] BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] LITTLE = 32'h1E1E_1E1E;

    always #4 clk = ~clk;

    mmio_ext_window dut_i (
        .clk(clk), .rst(rst), .strap_en(strap_en), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .bus_err(bus_err), .fb_big_endian(fb_big_endian), .rev_id(rev_id)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic in_win(input logic s, input logic [11:0] a);
        return s && a >= 12'h600 && a <= 12'h607;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic be);
        if (a == 12'h600) return 32'd8;
        if (a == 12'h604) return be ? BIG : LITTLE;
        return 32'd0;
    endfunction

    // Drive one access at a falling edge and check every output against the model.
    task automatic access(input string req, input logic s, input logic [11:0] a,
                          input logic [2:0] sz, input logic w, input logic [31:0] wd,
                          input logic r);
        logic        hit;
        logic [31:0] erd;
        logic        eerr;
        strap_en = s; bus_addr = a; bus_size = sz;
        bus_wr = w; bus_wdata = wd; bus_rd = r;
        #1;
        hit = in_win(s, a);
        check32({req, " R1 hit"}, 32'(bus_hit), 32'(hit));
        check32({req, " R8 rev"}, 32'(rev_id), s ? 32'd2 : 32'd1);
        erd  = (r && hit && sz == 3'd4) ? exp_read(a, model_be) : 32'd0;
        eerr = (r || w) && hit && sz != 3'd4;
        if (w && hit && sz == 3'd4 && a == 12'h604) begin
            if (wd == BIG) model_be = 1'b1;
            else if (wd == LITTLE) model_be = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check32({req, " R10 rdata"}, bus_rdata, erd);
        check32({req, " R7 err"}, 32'(bus_err), 32'(eerr));
        check32({req, " R4 R5 order"}, 32'(fb_big_endian), 32'(model_be));
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; strap_en = 1'b1; bus_addr = '0; bus_size = 3'd4;
        bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check32("R9 rdata", bus_rdata, 32'd0);
        check32("R9 err", 32'(bus_err), 32'd0);
        check32("R9 order", 32'(fb_big_endian), 32'd0);
        access("R9 first order read", 1, 12'h604, 3'd4, 0, 0, 1);
        access("R2 size read", 1, 12'h600, 3'd4, 0, 0, 1);
        access("R2 size write", 1, 12'h600, 3'd4, 1, BIG, 0);
        access("R2 size reread", 1, 12'h600, 3'd4, 0, 0, 1);
        access("R4 set big", 1, 12'h604, 3'd4, 1, BIG, 0);
        access("R3 read big", 1, 12'h604, 3'd4, 0, 0, 1);
        access("R5 near magic", 1, 12'h604, 3'd4, 1, 32'h1E1E_1E1F, 0);
        access("R5 readback", 1, 12'h604, 3'd4, 0, 0, 1);
        access("R10 rd+wr same cycle", 1, 12'h604, 3'd4, 1, LITTLE, 1);
        access("R3 read little", 1, 12'h604, 3'd4, 0, 0, 1);
        access("R6 hole write", 1, 12'h605, 3'd4, 1, BIG, 1);
        access("R6 hole read", 1, 12'h607, 3'd4, 0, 0, 1);
        access("R7 short magic", 1, 12'h604, 3'd2, 1, BIG, 0);
        access("R7 short read", 1, 12'h604, 3'd1, 0, 0, 1);
        access("R7 idle after err", 1, 12'h604, 3'd4, 0, 0, 0);
        access("R8 strap off write", 0, 12'h604, 3'd4, 1, BIG, 1);
        access("R8 strap off bad size", 0, 12'h600, 3'd2, 1, 0, 1);
        access("R1 outside window", 1, 12'h608, 3'd4, 0, 0, 1);
        access("R1 below window", 1, 12'h5FC, 3'd4, 0, 0, 1);
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [2:0]  sz;
            logic [31:0] wd;
            int          pick;
            a    = ($urandom % 4 != 0) ? (12'h600 + 12'($urandom % 8)) : 12'($urandom);
            if ($urandom % 2 == 0) a = {a[11:2], 2'b00};
            sz   = ($urandom % 3 != 0) ? 3'd4 : 3'($urandom);
            pick = int'($urandom % 5);
            case (pick)
                0: wd = BIG;
                1: wd = LITTLE;
                2: wd = BIG ^ (32'd1 << ($urandom % 32));
                3: wd = LITTLE ^ (32'd1 << ($urandom % 32));
                default: wd = $urandom;
            endcase
            access("random R4 R5 R7", ($urandom % 8) != 0, a, sz,
                   1'($urandom), wd, 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule